// File: doc/BRIEF.md
# Falling-Edge SPI Host Controller

This block is a single-lane SPI host. It takes bytes from a valid/ready transmit port and produces the serial clock, the serial data out line and one of two active-low chip selects. It assembles the bits returned on the serial data in line into received bytes. A divider built from the system clock sets the serial clock. With the default settings, a 250 MHz system clock gives a 31.25 MHz serial clock with equal high and low phases. The serial clock rests low. Outgoing data moves on a falling edge. Incoming data is also captured on a falling edge, so the remote device has most of a full period to answer.

A transaction starts when the first byte is accepted while the host is idle. That byte's select input picks the chip select. The host then waits a guard interval before the first rising clock edge. Each further byte belongs to the same transaction until a byte marked last has been shifted. After that byte the host waits a second guard interval and then releases the chip select. Each guard interval is given in picoseconds and rounded up to whole system clock cycles.

Top module: `spi_fe_host`

## Requirements
- R1: While reset is held and in the first cycle after it, both chip-select outputs are high, sclk is low, rx_valid is low and tx_ready is high.
- R2: Within a byte, every high phase and every low phase of sclk lasts HALF_DIV system cycles. The default of 4 gives 31.25 MHz with a 50% duty cycle from a 250 MHz clock.
- R3: sclk is low in every cycle in which no chip select is asserted.
- R4: mosi presents the transmit byte most significant bit first. The first bit is ready before the first rising edge, and mosi never changes while sclk is high.
- R5: miso is captured at each falling edge of sclk, most significant bit first. rx_valid is high for exactly one cycle, the cycle in which sclk has just fallen for the eighth time in a byte, and rx_data then holds the captured byte.
- R6: The first rising edge of sclk comes GUARD_CYC system cycles after the chip select goes low. GUARD_CYC is GUARD_PS divided by CLK_PS, rounded up, which is 8 by default.
- R7: The chip select goes high GUARD_CYC system cycles after the final falling edge of sclk in the transaction.
- R8: The chip select driven low is cs_n[tx_sel] for tx_sel sampled with the first byte of the transaction, so tx_sel = 0 selects cs_n[0]. At most one chip select is low at any time. tx_sel given with later bytes of the same transaction has no effect.
- R9: When the next byte is accepted before the current one ends, the chip select stays low and the low phase between the two bytes is also HALF_DIV cycles.
- R10: After a byte that is not marked last, if no further byte has been given, sclk stays low, the chip select stays low and tx_ready stays high until the next byte arrives. After a byte marked last has been accepted, tx_ready stays low until the host is idle again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | DATA_W (8) | Byte to send |
| tx_sel | input | SEL_W (1) | Chip-select index, used with the first byte of a transaction |
| tx_last | input | 1 | Marks the final byte of the transaction |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Host can take a byte this cycle |
| rx_data | output | DATA_W (8) | Last byte received |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| sclk | output | 1 | Serial clock, low at rest |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | N_CS (2) | Active-low chip selects |

## Verification
Every serial output is a register, so sclk and a chip select change at the same system edge that the control logic decides on. The bench samples all outputs at the falling system-clock edge. It counts samples between consecutive events: 8 samples from chip-select assertion to the first rise, 4 samples for each clock phase, and 8 samples from the last fall to release. rx_valid and rx_data are checked in the sample that first shows sclk low after the eighth fall. The bench's device model changes miso half a system cycle after it sees a fall, which is well clear of the host's next capture.

// File: rtl/spi_fe_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the falling-edge SPI host.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package spi_fe_pkg;

    // Transaction phases of the host sequencer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_WAIT,
        ST_HOLD
    } host_state_t;

    // Integer division rounded toward positive infinity.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/spi_fe_divider.sv
`timescale 1ns/1ps
// Half-period timer for the serial clock.
// Raises tick on the last cycle of each half period while run is high.
// Assumes HALF_DIV >= 2. The count is held at zero while run is low.
module spi_fe_divider #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV);
    localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == TOP);

    // Count system cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_fe_guard.sv
`timescale 1ns/1ps
// Guard-interval timer for chip-select setup and hold.
// done is high in the GUARD_CYC-th cycle of a continuous run.
// Assumes GUARD_CYC >= 1. The count clears whenever run is low.
module spi_fe_guard #(
    parameter int GUARD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int GW = $clog2(GUARD_CYC + 1);
    localparam logic [GW-1:0] LAST = GW'(GUARD_CYC - 1);

    logic [GW-1:0] cnt;

    assign done = run && (cnt == LAST);

    // Advance while the guard interval is running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_fe_shreg.sv
`timescale 1ns/1ps
// Combined transmit/receive shift register, MSB first.
// On shift, the outgoing bit leaves at the top and miso enters at the bottom.
// load wins over shift and restarts the bit count.
// Assumes DATA_W >= 2.
module spi_fe_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    input  logic              miso_in,
    output logic              mosi_out,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int BW = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    logic [DATA_W-1:0] sh;
    logic [BW-1:0]     bit_cnt;

    assign mosi_out  = sh[DATA_W-1];
    assign byte_done = shift && (bit_cnt == LAST_BIT);

    // Load a new byte or move one bit through the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            bit_cnt <= '0;
        end else if (load) begin
            sh      <= load_data;
            bit_cnt <= '0;
        end else if (shift) begin
            sh      <= {sh[DATA_W-2:0], miso_in};
            bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
        end
    end

    // Present the completed received byte with a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= byte_done;
            if (byte_done) begin
                rx_data <= {sh[DATA_W-2:0], miso_in};
            end
        end
    end
endmodule

// File: rtl/spi_fe_host.sv
`timescale 1ns/1ps
// SPI host: byte stream in, serial clock, data and chip selects out.
// Serial clock rests low. Data out changes and data in is captured on
// falling edges. Guard intervals of GUARD_CYC system cycles separate the
// chip-select edges from the first rise and the last fall.
// Assumes tx_* inputs follow valid/ready rules and miso is synchronous.
module spi_fe_host
    import spi_fe_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int N_CS     = 2,
    parameter int HALF_DIV = 4,
    parameter int CLK_PS   = 4000,
    parameter int GUARD_PS = 30000,
    localparam int SEL_W   = (N_CS > 1) ? $clog2(N_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [SEL_W-1:0]  tx_sel,
    input  logic              tx_last,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [N_CS-1:0]   cs_n
);
    localparam int GUARD_CYC = ceil_div(GUARD_PS, CLK_PS);

    host_state_t state, state_nx;

    logic              half_tick, guard_done;
    logic              fall, rise, byte_done;
    logic              accept, idle_acc, pend_acc, pend_take, load;
    logic [DATA_W-1:0] load_data;
    logic [DATA_W-1:0] pend_data;
    logic              pend_full, pend_last;
    logic              cur_last, last_seen;
    logic [N_CS-1:0]   sel_dec;

    // One-hot decode of the requested chip select.
    for (genvar g = 0; g < N_CS; g++) begin : g_sel
        assign sel_dec[g] = (tx_sel == SEL_W'(g));
    end

    spi_fe_divider #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_SHIFT),
        .tick  (half_tick)
    );

    spi_fe_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((state == ST_SETUP) || (state == ST_HOLD)),
        .done  (guard_done)
    );

    spi_fe_shreg #(.DATA_W(DATA_W)) u_sh (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (load_data),
        .shift     (fall),
        .miso_in   (miso),
        .mosi_out  (mosi),
        .byte_done (byte_done),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    // Edge decisions and transmit handshake decode.
    always_comb begin
        fall      = (state == ST_SHIFT) && sclk && half_tick;
        rise      = (state == ST_SHIFT) && !sclk && half_tick;
        tx_ready  = (state == ST_IDLE) ||
                    (((state == ST_SETUP) || (state == ST_SHIFT) || (state == ST_WAIT))
                     && !pend_full && !last_seen);
        accept    = tx_valid && tx_ready;
        idle_acc  = accept && (state == ST_IDLE);
        pend_acc  = accept && (state != ST_IDLE);
        pend_take = pend_full &&
                    ((byte_done && !cur_last) || (state == ST_WAIT));
        load      = idle_acc || pend_take;
        load_data = (state == ST_IDLE) ? tx_data : pend_data;
    end

    // Next-phase selection for the sequencer.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (idle_acc)   state_nx = ST_SETUP;
            ST_SETUP: if (guard_done) state_nx = ST_SHIFT;
            ST_SHIFT: if (byte_done) begin
                          if (cur_last)       state_nx = ST_HOLD;
                          else if (pend_full) state_nx = ST_SHIFT;
                          else                state_nx = ST_WAIT;
                      end
            ST_WAIT:  if (pend_full)  state_nx = ST_SHIFT;
            ST_HOLD:  if (guard_done) state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Serial clock output register.
    always_ff @(posedge clk) begin
        if (!rst_n)                               sclk <= 1'b0;
        else if ((state == ST_SETUP) && guard_done) sclk <= 1'b1;
        else if (fall)                            sclk <= 1'b0;
        else if (rise)                            sclk <= 1'b1;
    end

    // Chip-select output register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cs_n <= '1;
        else if (idle_acc)                         cs_n <= ~sel_dec;
        else if ((state == ST_HOLD) && guard_done) cs_n <= '1;
    end

    // One-entry holding register for the next byte of a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_full <= 1'b0;
            pend_last <= 1'b0;
            pend_data <= '0;
        end else if (pend_acc) begin
            pend_full <= 1'b1;
            pend_last <= tx_last;
            pend_data <= tx_data;
        end else if (pend_take) begin
            pend_full <= 1'b0;
        end
    end

    // Track whether the byte in flight and the transaction are finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_last  <= 1'b0;
            last_seen <= 1'b0;
        end else begin
            if (idle_acc)       cur_last <= tx_last;
            else if (pend_take) cur_last <= pend_last;
            if (idle_acc)                  last_seen <= tx_last;
            else if (pend_acc && tx_last)  last_seen <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_fe_host_chk.sv
`timescale 1ns/1ps
// Protocol checker for spi_fe_host, bound to every instance.
// Counts phase lengths at the pins and checks timing and exclusivity.
module spi_fe_host_chk #(
    parameter int HALF_DIV  = 4,
    parameter int GUARD_CYC = 8,
    parameter int N_CS      = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sclk,
    input logic            mosi,
    input logic            rx_valid,
    input logic [N_CS-1:0] cs_n
);
    localparam int HW = $clog2(HALF_DIV + 2);
    localparam int GW = $clog2(GUARD_CYC + 1);
    localparam logic [HW-1:0] HI_MAX = HW'(HALF_DIV + 1);
    localparam logic [GW-1:0] G_MAX  = GW'(GUARD_CYC);

    logic [HW-1:0] hi_cnt;
    logic [GW-1:0] lo_cnt, sel_cnt;

    // Length of the current high phase, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !sclk)      hi_cnt <= '0;
        else if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
    end

    // Cycles since sclk last went low, saturating at the guard length.
    always_ff @(posedge clk) begin
        if (!rst_n || sclk)       lo_cnt <= '0;
        else if (lo_cnt != G_MAX) lo_cnt <= lo_cnt + 1'b1;
    end

    // Cycles a chip select has been low, saturating at the guard length.
    always_ff @(posedge clk) begin
        if (!rst_n || (&cs_n))     sel_cnt <= '0;
        else if (sel_cnt != G_MAX) sel_cnt <= sel_cnt + 1'b1;
    end

    p_high_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_cnt == HW'(HALF_DIV)));

    p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sclk);

    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    p_rx_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $fell(sclk));

    p_rx_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_cs_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (sel_cnt >= G_MAX));

    p_cs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cs_n) && !$past(&cs_n)) |-> (lo_cnt >= G_MAX));

    p_one_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
endmodule

bind spi_fe_host spi_fe_host_chk #(
    .HALF_DIV  (HALF_DIV),
    .GUARD_CYC (GUARD_CYC),
    .N_CS      (N_CS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .rx_valid (rx_valid),
    .cs_n     (cs_n)
);

// File: tb/sim_spi_fe_host.sv
`timescale 1ns/1ps
module sim_spi_fe_host;
    localparam int HALF  = 4;
    localparam int GUARD = 8;   // ceil(30000 / 4000)
    localparam int NTAB  = 7;
    localparam int NALL  = 9;

    // {sel, last, tx byte, device reply byte}
    localparam logic [17:0] VEC [NTAB] = '{
        {1'b0, 1'b1, 8'hA5, 8'h3C},
        {1'b1, 1'b0, 8'h81, 8'h7E},
        {1'b0, 1'b0, 8'h00, 8'hFF},   // sel ignored (R8)
        {1'b1, 1'b1, 8'hFF, 8'h00},
        {1'b0, 1'b0, 8'h5A, 8'hC3},
        {1'b0, 1'b1, 8'h96, 8'h69},
        {1'b1, 1'b1, 8'h01, 8'h80}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_sel = 1'b0;
    logic       tx_last = 1'b0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       sclk;
    logic       mosi;
    logic       miso = 1'b0;
    logic [1:0] cs_n;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    logic [7:0] e_tx  [NALL];
    logic [7:0] e_slv [NALL];
    logic       e_sel [NALL];
    logic       e_lst [NALL];

    int         j = 0;
    int         nbit = 0;
    int         cnt = 0;
    logic [7:0] mcap = '0;
    bit         first_rise = 0;
    bit         stall_ok = 0;
    bit         mon_en = 0;
    int         r3_bad = 0;
    int         rxv_bad = 0;

    spi_fe_host u0 (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_sel(tx_sel),
        .tx_last(tx_last), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int k);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_sel   = e_sel[k];
        tx_last  = e_lst[k];
        tx_data  = e_tx[k];
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_byte(input int target);
        while (j < target) @(negedge clk);
    endtask

    // Pin monitor and device model, sampling at the falling system edge.
    initial begin
        logic ps = 1'b0;
        bit   pa = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_en) begin
                bit act;
                act = (cs_n != 2'b11);
                if (!act && sclk) r3_bad++;
                if (act && !pa) begin
                    chk(cs_n == ~(2'b01 << e_sel[j]), "R8 cs choice", cs_n, ~(2'b01 << e_sel[j]));
                    first_rise = 1; nbit = 0; cnt = 1;
                    miso = e_slv[j][7];
                end else if (!act && pa) begin
                    chk(cnt == GUARD, "R7 hold cycles", cnt, GUARD);
                    cnt = 1;
                end else if (sclk && !ps) begin
                    if (first_rise) chk(cnt == GUARD, "R6 setup cycles", cnt, GUARD);
                    else if (!stall_ok && nbit == 0) chk(cnt == HALF, "R9 gap low", cnt, HALF);
                    else if (!stall_ok) chk(cnt == HALF, "R2 low phase", cnt, HALF);
                    first_rise = 0;
                    mcap = {mcap[6:0], mosi};
                    cnt = 1;
                end else if (!sclk && ps) begin
                    chk(cnt == HALF, "R2 high phase", cnt, HALF);
                    nbit++;
                    cnt = 1;
                    if (nbit == 8) begin
                        chk(rx_valid && rx_data == e_slv[j], "R5 rx byte", {rx_valid, rx_data}, {1'b1, e_slv[j]});
                        chk(mcap == e_tx[j], "R4 mosi byte", mcap, e_tx[j]);
                        j++;
                        nbit = 0;
                        miso = (j < NALL) ? e_slv[j][7] : 1'b0;
                    end else begin
                        if (rx_valid) rxv_bad++;
                        miso = e_slv[j][7 - nbit];
                    end
                end else begin
                    if (rx_valid) rxv_bad++;
                    cnt++;
                end
                ps = sclk;
                pa = act;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", j, NALL);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        bit start = 1;
        logic cur = 1'b0;
        for (int k = 0; k < NTAB; k++) begin
            e_tx[k]  = VEC[k][15:8];
            e_slv[k] = VEC[k][7:0];
            e_lst[k] = VEC[k][16];
            if (start) cur = VEC[k][17];
            e_sel[k] = cur;
            start = VEC[k][16];
        end
        // Directed stall transaction: second byte's sel=1 must be ignored.
        e_tx[7] = 8'hC7; e_slv[7] = 8'h1E; e_lst[7] = 1'b0; e_sel[7] = 1'b0;
        e_tx[8] = 8'h3B; e_slv[8] = 8'hD4; e_lst[8] = 1'b1; e_sel[8] = 1'b0;

        // R1: reset state, during and just after reset.
        repeat (3) @(negedge clk);
        chk(cs_n == 2'b11 && sclk == 1'b0, "R1 cs/sclk in reset", {cs_n, sclk}, 3'b110);
        chk(rx_valid == 1'b0, "R1 rx_valid in reset", rx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 2'b11 && sclk == 1'b0, "R1 cs/sclk after reset", {cs_n, sclk}, 3'b110);
        chk(tx_ready == 1'b1 && rx_valid == 1'b0, "R1 ready/valid after reset", {tx_ready, rx_valid}, 2'b10);
        mon_en = 1;

        // Table walk: R2 R4 R5 R6 R7 R8 R9.
        for (int k = 0; k < NTAB; k++) push(k);
        wait_byte(NTAB);
        while (cs_n != 2'b11) @(negedge clk);

        // R10: stall between bytes with no next byte offered.
        stall_ok = 1;
        push(7);
        wait_byte(8);
        repeat (30) @(negedge clk);
        chk(sclk == 1'b0 && cs_n == 2'b10, "R10 stalled pins", {sclk, cs_n}, 3'b010);
        chk(tx_ready == 1'b1, "R10 ready while stalled", tx_ready, 1);
        e_sel[8] = 1'b1;   // drive sel=1 on the second byte
        push(8);
        e_sel[8] = 1'b0;   // expectation: still cs_n[0]
        @(negedge clk);
        chk(tx_ready == 1'b0, "R10 ready low after last", tx_ready, 0);
        wait_byte(NALL);
        while (cs_n != 2'b11) @(negedge clk);
        repeat (4) @(negedge clk);

        chk(r3_bad == 0, "R3 sclk idle low", r3_bad, 0);
        chk(rxv_bad == 0, "R5 no stray rx_valid", rxv_bad, 0);
        chk(tx_ready == 1'b1 && sclk == 1'b0, "R3 idle at end", {tx_ready, sclk}, 2'b10);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule